// File: doc/BRIEF.md
# JEDEC Identification Read Responder

This block is the device-side part of a serial flash interface that answers the standard identification query. It watches a mode-0 SPI bus made of an active-low select, a serial clock and a data input. All three are brought into the block's clock domain through a short synchronizer chain. Once a select window opens, the block collects the first eight bits as an opcode. If they equal 9Fh, it streams four identification bytes on the serial output. The first is the vendor code, the next two are the device code (high byte first), and the last is an extended-information length of zero. Every byte goes out MSB first.

The output enable is only raised while that stream is under way. Releasing the select line drops it combinationally, at any bit position. Any other opcode silences the output for the rest of the window. After the fourth byte the block keeps sending zero bits for as long as the host keeps clocking. The three identification values are parameters, so one netlist serves several device variants.

Top module: `jedec_id_responder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `so_oe` and `so` are 0, even if the select line is low.
- R2: The opcode is the first 8 bits sampled on rising SCK edges after select goes low, MSB first. Only the value 9Fh starts the identification stream.
- R3: The MSB of the first byte is driven on the SCK falling edge that follows the 8th opcode rising edge, so it is valid at the 9th rising edge. After that, `so` changes only after an SCK falling edge.
- R4: The stream order is `MFR_ID`, `DEV_ID_HI`, `DEV_ID_LO`, 00h, each byte MSB first, one bit per SCK cycle.
- R5: From the 33rd output bit onward, `so` stays 0 while `so_oe` stays 1 until select is released.
- R6: Any opcode other than 9Fh keeps `so_oe` at 0 until the select line goes high.
- R7: `so_oe` is 0 whenever `cs_n` is 1, with no clock delay, including partway through a byte.
- R8: Raising the select line discards a partial opcode, so the next window starts counting opcode bits from zero.
- R9: `so_oe` is 0 for the whole opcode phase.
- R10: `so` reads 0 whenever `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Serial clock, idles low (mode 0) |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for the `so` pad driver |

## Verification
The bench targets the handoff at the 9th SCK edge. A design that drives on the wrong edge would show the manufacturer MSB one bit late, or not at all, when it is sampled before that edge. Reads that run past 32 bits catch a stream that wraps back to the vendor byte instead of padding with zeros. Opcodes one bit away from 9Fh, all-zero and all-one opcodes, and a select pulse that cuts an opcode short all target a decoder that matches loosely or that carries a bit count across windows. Releasing select in the middle of a byte catches an enable that waits for a synchronized copy of the select line.

// File: rtl/jid_pkg.sv
package jid_pkg;

    localparam int OP_BITS  = 8;
    localparam int CNT_W    = $clog2(OP_BITS);
    localparam int ID_BYTES = 4;
    localparam int IDX_W    = $clog2(ID_BYTES + 1);

    localparam logic [OP_BITS-1:0] JID_OPCODE = 8'h9F;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_STREAM = 2'd1,
        ST_MUTE   = 2'd2
    } jid_state_e;

    typedef struct packed {
        logic cs_n;
        logic rise;
        logic fall;
        logic si;
    } jid_pins_t;

    // Byte of the identification stream at a given index; past the
    // three programmed bytes everything reads as zero.
    function automatic logic [7:0] jid_byte_sel(
        input logic [IDX_W-1:0] idx,
        input logic [7:0]       mfr,
        input logic [7:0]       dev_hi,
        input logic [7:0]       dev_lo
    );
        case (idx)
            IDX_W'(0): return mfr;
            IDX_W'(1): return dev_hi;
            IDX_W'(2): return dev_lo;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/jid_sync.sv
module jid_sync
    import jid_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sck,
    input  logic      si,
    output jid_pins_t pins
);

    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] si_q;
    logic              sck_last;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q[0]  <= 1'b1;
                    sck_q[0] <= 1'b0;
                    si_q[0]  <= 1'b0;
                end else begin
                    cs_q[0]  <= cs_n;
                    sck_q[0] <= sck;
                    si_q[0]  <= si;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    cs_q[i]  <= 1'b1;
                    sck_q[i] <= 1'b0;
                    si_q[i]  <= 1'b0;
                end else begin
                    cs_q[i]  <= cs_q[i-1];
                    sck_q[i] <= sck_q[i-1];
                    si_q[i]  <= si_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sck_last <= 1'b0;
        else     sck_last <= sck_q[STAGES-1];
    end

    always_comb begin
        pins.cs_n = cs_q[STAGES-1];
        pins.rise = sck_q[STAGES-1] & ~sck_last;
        pins.fall = ~sck_q[STAGES-1] & sck_last;
        pins.si   = si_q[STAGES-1];
    end

endmodule

// File: rtl/jid_cmd_rx.sv
module jid_cmd_rx
    import jid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_s,
    input  logic       rise_s,
    input  logic       si_s,
    output jid_state_e state
);

    logic [OP_BITS-2:0] op_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [OP_BITS-1:0] op_full;

    assign op_full = {op_q, si_s};

    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            state <= ST_OPCODE;
            op_q  <= '0;
            cnt_q <= '0;
        end else if (state == ST_OPCODE && rise_s) begin
            op_q  <= op_full[OP_BITS-2:0];
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(OP_BITS - 1)) begin
                state <= (op_full == JID_OPCODE) ? ST_STREAM : ST_MUTE;
            end
        end
    end

endmodule

// File: rtl/jid_tx.sv
module jid_tx
    import jid_pkg::*;
#(
    parameter logic [7:0] MFR_ID    = 8'hC2,
    parameter logic [7:0] DEV_ID_HI = 8'h5A,
    parameter logic [7:0] DEV_ID_LO = 8'h3B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_s,
    input  logic             fall_s,
    input  jid_state_e       state,
    output logic             drive,
    output logic             bit_out,
    output logic [IDX_W-1:0] byte_idx
);

    logic [2:0] bit_idx;
    logic [7:0] cur_byte;

    assign cur_byte = jid_byte_sel(byte_idx, MFR_ID, DEV_ID_HI, DEV_ID_LO);

    always_ff @(posedge clk) begin
        if (rst || cs_s || state != ST_STREAM) begin
            drive    <= 1'b0;
            bit_out  <= 1'b0;
            bit_idx  <= '0;
            byte_idx <= '0;
        end else if (fall_s) begin
            drive   <= 1'b1;
            bit_out <= cur_byte[3'd7 - bit_idx];
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7 && byte_idx != IDX_W'(ID_BYTES)) begin
                byte_idx <= byte_idx + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/jedec_id_responder.sv
module jedec_id_responder
    import jid_pkg::*;
#(
    parameter logic [7:0] MFR_ID      = 8'hC2,
    parameter logic [7:0] DEV_ID_HI   = 8'h5A,
    parameter logic [7:0] DEV_ID_LO   = 8'h3B,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);

    jid_pins_t        pins;
    logic             cs_s, rise_s, fall_s, si_s;
    jid_state_e       rx_state;
    logic             tx_drive;
    logic             tx_bit;
    logic [IDX_W-1:0] tx_byte_idx;

    jid_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .cs_n(cs_n),
        .sck (sck),
        .si  (si),
        .pins(pins)
    );

    assign cs_s   = pins.cs_n;
    assign rise_s = pins.rise;
    assign fall_s = pins.fall;
    assign si_s   = pins.si;

    jid_cmd_rx cmd_i (
        .clk   (clk),
        .rst   (rst),
        .cs_s  (cs_s),
        .rise_s(rise_s),
        .si_s  (si_s),
        .state (rx_state)
    );

    jid_tx #(
        .MFR_ID   (MFR_ID),
        .DEV_ID_HI(DEV_ID_HI),
        .DEV_ID_LO(DEV_ID_LO)
    ) tx_i (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (cs_s),
        .fall_s  (fall_s),
        .state   (rx_state),
        .drive   (tx_drive),
        .bit_out (tx_bit),
        .byte_idx(tx_byte_idx)
    );

    // The raw select gates the enable so a release floats the pin at once.
    assign so_oe = tx_drive & ~cs_n;
    assign so    = tx_bit & so_oe;

endmodule

// File: rtl/jid_checker.sv
module jid_checker
    import jid_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             cs_s,
    input logic             sck_fall,
    input jid_state_e       state,
    input logic [IDX_W-1:0] byte_idx,
    input logic             so,
    input logic             so_oe
);

    assert_float_on_release_R7: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !so_oe);

    assert_quiet_unless_streaming_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_STREAM) |-> !so_oe);  // also covers R9

    assert_so_moves_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));

    assert_new_window_R8: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> (state == ST_OPCODE));

    assert_pad_index_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        byte_idx <= IDX_W'(ID_BYTES));

    assert_low_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !so_oe |-> !so);

endmodule

bind jedec_id_responder jid_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .cs_s    (cs_s),
    .sck_fall(fall_s),
    .state   (rx_state),
    .byte_idx(tx_byte_idx),
    .so      (so),
    .so_oe   (so_oe)
);

// File: tb/jedec_id_responder_tb_top.sv
`timescale 1ns/1ps
module jedec_id_responder_tb_top;

    localparam logic [7:0] P_MFR = 8'hC2;
    localparam logic [7:0] P_DHI = 8'h5A;
    localparam logic [7:0] P_DLO = 8'h3B;
    localparam int HALF = 8;
    localparam int NVEC = 7;
    // {opcode, number of bits read after it}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h9F20, 16'h9F30, 16'h9E10, 16'h1F10, 16'h0008, 16'hFF08, 16'h9F05
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    jedec_id_responder #(
        .MFR_ID(P_MFR), .DEV_ID_HI(P_DHI), .DEV_ID_LO(P_DLO), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe)
    );

    function automatic logic exp_bit(int n);
        logic [7:0] b;
        case (n / 8)
            0: b = P_MFR;
            1: b = P_DHI;
            2: b = P_DLO;
            default: b = 8'h00;
        endcase
        return b[7 - (n % 8)];
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit();
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic send_opcode_bits(input logic [7:0] op, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            si = op[7 - b];
            wait_clk(HALF);
            check(so_oe, 1'b0, "R9 oe during opcode");
            clock_bit();
        end
    endtask

    task automatic read_bits(input logic [7:0] op, input int nread);
        for (int i = 0; i < nread; i++) begin
            si = i[0] ^ i[2];
            wait_clk(HALF);
            if (op == 8'h9F) begin
                check(so_oe, 1'b1, (i == 0) ? "R2 R3 oe on" : "R4 oe on");
                check(so, exp_bit(i),
                      (i == 0) ? "R3 first bit" : (i < 32) ? "R4 stream bit" : "R5 pad bit");
            end else begin
                check(so_oe, 1'b0, "R6 mute oe");
                check(so, 1'b0, "R10 so low when off");
            end
            clock_bit();
        end
    endtask

    task automatic release_cs();
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        check(so_oe, 1'b0, "R7 immediate float");
        check(so, 1'b0, "R10 so low after release");
        wait_clk(6);
    endtask

    task automatic xfer(input logic [7:0] op, input int nread);
        cs_n = 1'b0;
        wait_clk(HALF);
        send_opcode_bits(op, 8);
        read_bits(op, nread);
        release_cs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cs_n = 1'b0;   // select low during reset must not enable output
        wait_clk(5);
        check(so_oe, 1'b0, "R1 oe in reset");
        check(so, 1'b0, "R1 so in reset");
        rst = 1'b0;
        cs_n = 1'b1;
        @(negedge clk);
        check(so_oe, 1'b0, "R1 oe after reset");
        wait_clk(6);

        // Table-driven windows
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][15:8], int'(VEC[v][7:0]));
        end

        // R8: partial opcode cut short by select release, then full read
        cs_n = 1'b0;
        wait_clk(HALF);
        send_opcode_bits(8'h9F, 4);
        release_cs();
        xfer(8'h9F, 16);

        // R7: release in the middle of the second byte while SCK is high
        cs_n = 1'b0;
        wait_clk(HALF);
        send_opcode_bits(8'h9F, 8);
        read_bits(8'h9F, 10);
        sck = 1'b1;
        wait_clk(2);
        cs_n = 1'b1;
        #1;
        check(so_oe, 1'b0, "R7 float with sck high");
        wait_clk(HALF);
        sck = 1'b0;
        wait_clk(6);

        // R1: reset in the middle of a stream
        cs_n = 1'b0;
        wait_clk(HALF);
        send_opcode_bits(8'h9F, 8);
        read_bits(8'h9F, 3);
        rst = 1'b1;
        wait_clk(2);
        check(so_oe, 1'b0, "R1 oe after mid-stream reset");
        rst = 1'b0;
        cs_n = 1'b1;
        wait_clk(6);

        // Stream still correct after that reset
        xfer(8'h9F, 40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule